// File: doc/BRIEF.md
# UART Baud Rate Tick Generator

This block produces the two timing pulses a UART needs: an oversample tick at sixteen times the bit rate, and a bit tick at the bit rate. Everything runs on the system clock. The divider counts one of two event sources. In one mode it counts every system clock cycle. In the other it counts rising edges of an external pin clock. That pin clock is first brought into the system domain through a synchronizer chain, and an edge detector follows it.

A 16-bit divisor register sets how many counted events make up one oversample tick. A divide-by-16 phase counter then derives the bit tick from the oversample ticks. The value to program is the source frequency divided by sixteen times the wanted baud rate. Writing the divisor or flipping the source select restarts both counters. The divider also reloads itself from the divisor register each time it reaches its terminal count. As a result, no shortened period is ever produced.

Top module: `uart_baud_gen`

## Requirements
- R1: While reset is asserted both tick outputs are low. After reset the divisor holds 1 and the system clock is the source, so the oversample tick pulses on every cycle.
- R2: With the system clock selected and an effective divisor N, the oversample tick pulses exactly once every N system clock cycles. The first pulse comes N cycles after the reload edge.
- R3: The bit tick pulses together with every 16th oversample tick counted since the last restart, and only in the same cycle as an oversample tick.
- R4: A divisor value of 0 behaves exactly like a divisor of 1.
- R5: With the pin clock selected (select = 1), each rising edge of the pin counts as one event. An edge sampled at system clock edge t becomes a counted event at edge t+2, after two synchronizer flops.
- R6: A divisor write restarts the divider from the new value and clears the divide-by-16 phase. No tick is issued in the restart cycle, even if the terminal count falls in that same cycle.
- R7: Any change of the source select restarts the divider and phase in the same way as R6, and likewise issues no tick in the restart cycle.
- R8: Each tick is a single-cycle pulse. In pin-clock mode the oversample tick is never high on two consecutive cycles, and the bit tick never is in either mode.
- R9: In pin-clock mode, a pin held at a constant level produces no ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| uclkIn | input | 1 | Raw external pin clock, asynchronous to clk |
| srcSel | input | 1 | Count source: 0 = system clock, 1 = pin clock edges |
| divWrEn | input | 1 | Divisor write strobe |
| divWrData | input | 16 | New divisor value |
| ovsTick | output | 1 | Oversample tick pulse |
| bitTick | output | 1 | Bit-rate tick pulse |

## Verification
A restart, caused by a divisor write or a select change, can fall in the same cycle as the divider's terminal count. The bench provokes this on purpose. It rewrites the divisor exactly N cycles after a previous write, and it flips the select while a terminal count is pending. A reference model in the bench predicts that the restart wins and that no tick appears. Both outputs are compared against that model on every cycle, so any tick leaking through the collision is reported.

// File: rtl/baud_pkg.sv
package baud_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic advance;  // one counted source event this cycle
    logic reload;   // restart divider and phase counter
  } baudStrobes_t;

endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         uclkIn,
  input  logic         srcSel,
  input  logic         divWrEn,
  output baudStrobes_t strobes
);

  localparam int CHAIN_W = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [CHAIN_W-1:0] syncChain;
  logic               uclkSync;
  logic               uclkPrev;
  logic               selQ;
  logic               uclkRise;
  logic               selChanged;

  // Synchronizer chain for the asynchronous pin clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      uclkPrev  <= 1'b0;
      selQ      <= 1'b0;
    end else begin
      syncChain <= {syncChain[CHAIN_W-2:0], uclkIn};
      uclkPrev  <= uclkSync;
      selQ      <= srcSel;
    end
  end

  assign uclkSync   = syncChain[CHAIN_W-1];
  assign uclkRise   = uclkSync & ~uclkPrev;
  assign selChanged = srcSel ^ selQ;

  always_comb begin
    strobes.reload  = divWrEn | selChanged;
    strobes.advance = srcSel ? uclkRise : 1'b1;
  end

  // R5: a detected edge is always followed by a non-edge cycle
  assert_rise_isolated_R5: assert property (@(posedge clk) disable iff (!rstN)
    uclkRise |=> !uclkRise);

endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baud_pkg::*;
#(
  parameter int          DIV_W      = 16,
  parameter int          OVERSAMPLE = 16,
  parameter logic [15:0] RESET_DIV  = 16'd1
) (
  input  logic             clk,
  input  logic             rstN,
  input  baudStrobes_t     strobes,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  output logic             ovsTick,
  output logic             bitTick
);

  localparam int               PHASE_W   = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(OVERSAMPLE - 1);
  localparam logic [DIV_W-1:0] DIV_ONE   = DIV_W'(1);
  localparam logic [DIV_W-1:0] DIV_INIT  = (RESET_DIV == 16'd0) ? DIV_ONE : DIV_W'(RESET_DIV);

  logic [DIV_W-1:0]   divReg;
  logic [DIV_W-1:0]   divEff;
  logic [DIV_W-1:0]   wrEff;
  logic [DIV_W-1:0]   loadVal;
  logic [DIV_W-1:0]   cnt;
  logic [PHASE_W-1:0] phase;
  logic               termHit;

  // Zero divisor is promoted to one (R4)
  assign divEff  = (divReg == '0) ? DIV_ONE : divReg;
  assign wrEff   = (divWrData == '0) ? DIV_ONE : divWrData;
  assign loadVal = divWrEn ? wrEff : divEff;
  assign termHit = strobes.advance && (cnt == '0) && !strobes.reload;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= DIV_INIT;
    end else if (divWrEn) begin
      divReg <= divWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= DIV_INIT - DIV_ONE;
      phase   <= '0;
      ovsTick <= 1'b0;
      bitTick <= 1'b0;
    end else begin
      ovsTick <= termHit;
      bitTick <= termHit && (phase == PHASE_LAST);
      if (strobes.reload) begin
        cnt   <= loadVal - DIV_ONE;
        phase <= '0;
      end else if (strobes.advance) begin
        if (cnt == '0) begin
          cnt   <= divEff - DIV_ONE;
          phase <= (phase == PHASE_LAST) ? '0 : phase + 1'b1;
        end else begin
          cnt <= cnt - DIV_ONE;
        end
      end
    end
  end

  // R2: the down counter stays inside the programmed period
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    cnt < divEff);

  // R3: bit tick only together with an oversample tick
  assert_bit_with_ovs_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> ovsTick);

  // R8: bit tick is a single-cycle pulse
  assert_bit_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |=> !bitTick);

  // R6: a restart cycle is followed by quiet outputs
  assert_reload_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reload |=> (!ovsTick && !bitTick));

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import baud_pkg::*;
#(
  parameter int          DIV_W       = 16,
  parameter int          OVERSAMPLE  = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] RESET_DIV   = 16'd1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             uclkIn,
  input  logic             srcSel,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  output logic             ovsTick,
  output logic             bitTick
);

  baudStrobes_t strobes;

  baud_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .uclkIn (uclkIn),
    .srcSel (srcSel),
    .divWrEn(divWrEn),
    .strobes(strobes)
  );

  baud_datapath #(
    .DIV_W     (DIV_W),
    .OVERSAMPLE(OVERSAMPLE),
    .RESET_DIV (RESET_DIV)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .divWrEn  (divWrEn),
    .divWrData(divWrData),
    .ovsTick  (ovsTick),
    .bitTick  (bitTick)
  );

  // R8: in pin-clock mode oversample ticks are never back to back
  assert_ovs_single_uclk_R8: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel && $past(srcSel) && ovsTick) |=> !ovsTick);

endmodule

// File: tb/test_uart_baud_gen.sv
module test_uart_baud_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        uclkIn = 1'b0;
  logic        srcSel = 1'b0;
  logic        divWrEn = 1'b0;
  logic [15:0] divWrData = 16'd0;
  logic        ovsTick;
  logic        bitTick;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit doneFlag = 0;

  // behavioural reference state
  int  uq[$];
  int  mDiv, mAdv, mPh, mSelQ;
  bit  expOvs, expBit;

  always #2 clk = ~clk;  // 250 MHz

  uart_baud_gen i_uart_baud_gen (
    .clk(clk), .rstN(rstN), .uclkIn(uclkIn), .srcSel(srcSel),
    .divWrEn(divWrEn), .divWrData(divWrData),
    .ovsTick(ovsTick), .bitTick(bitTick)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      uq = {0, 0, 0};
      mDiv = 1; mAdv = 0; mPh = 0; mSelQ = 0;
      expOvs = 0; expBit = 0;
    end else begin
      bit rise, reload, adv;
      rise = (uq[1] == 1) && (uq[2] == 0);
      uq.push_front(int'(uclkIn));
      void'(uq.pop_back());
      reload = divWrEn || (int'(srcSel) != mSelQ);
      mSelQ = int'(srcSel);
      adv = srcSel ? rise : 1'b1;
      expOvs = 0; expBit = 0;
      if (divWrEn) mDiv = (divWrData == 0) ? 1 : int'(divWrData);
      if (reload) begin
        mAdv = 0; mPh = 0;
      end else if (adv) begin
        mAdv++;
        if (mAdv >= mDiv) begin
          mAdv = 0;
          expOvs = 1;
          if (mPh == 15) begin expBit = 1; mPh = 0; end
          else mPh++;
        end
      end
    end
  end

  task automatic checkOut();
    checks++;
    if (ovsTick !== expOvs || bitTick !== expBit) begin
      errors++;
      $display("FAIL %s: ovsTick=%0b bitTick=%0b expected ovsTick=%0b bitTick=%0b at %0t",
               curReq, ovsTick, bitTick, expOvs, expBit, $time);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checkOut();
    end
  endtask

  task automatic writeDiv(logic [15:0] v);
    divWrEn = 1'b1; divWrData = v;
    step(1);
    divWrEn = 1'b0;
  endtask

  task automatic uclkRun(int cycles, int half);
    for (int i = 0; i < cycles; i++) begin
      uclkIn = ((i / half) % 2) != 0;
      step(1);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run incomplete, actual hung expected done");
    finishRun();
  end

  initial begin
    int seen;
    // R1: reset state
    curReq = "R1";
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (ovsTick !== 1'b0 || bitTick !== 1'b0) begin
        errors++;
        $display("FAIL R1: during reset ovs=%0b bit=%0b expected 0 0", ovsTick, bitTick);
      end
    end
    rstN = 1'b1;
    step(40);                         // R1: divisor 1 after reset

    curReq = "R2"; writeDiv(16'd5); step(200);
    curReq = "R3"; writeDiv(16'd2); step(100);
    curReq = "R4"; writeDiv(16'd0); step(40);

    // R6: collision of write with terminal count
    curReq = "R6";
    writeDiv(16'd4); step(3); writeDiv(16'd4); step(3); writeDiv(16'd7);
    step(10); writeDiv(16'd3); step(1); writeDiv(16'd9); step(60);

    // R7: select change, also on a pending terminal count
    curReq = "R7";
    writeDiv(16'd3); step(2);
    srcSel = 1'b1; step(1); srcSel = 1'b0; step(2); srcSel = 1'b1; step(5);

    // R5: pin-clock counting, slow and fastest patterns
    curReq = "R5"; writeDiv(16'd2); uclkRun(400, 3);
    curReq = "R8"; writeDiv(16'd1); uclkRun(200, 1);
    writeDiv(16'd3); uclkRun(150, 2);

    // R9: pin held high gives no ticks
    curReq = "R9";
    uclkIn = 1'b1; step(4);
    seen = 0;
    for (int i = 0; i < 80; i++) begin
      step(1);
      if (ovsTick) seen++;
    end
    checks++;
    if (seen != 0) begin
      errors++;
      $display("FAIL R9: ticks seen=%0d expected 0", seen);
    end

    // R7: back to system clock while pin running
    curReq = "R7";
    uclkIn = 1'b0; srcSel = 1'b0; writeDiv(16'd6); step(50);
    srcSel = 1'b1; uclkRun(60, 2); srcSel = 1'b0; step(40);

    finishRun();
  end

endmodule